// File: doc/BRIEF.md
# Subtract Instruction Unit

This block carries out one eight-bit subtraction instruction for a small machine built around a 256-entry byte register file. Instruction bytes come in on a valid/ready stream. The unit reads the opcode and then the one or two operand bytes that the opcode calls for. It fetches the two operands, which may go through one level of indirection, and writes the difference back into the destination register. It then updates a six-bit condition register.

Five opcodes select the addressing mode. Two use 4-bit working-register numbers packed into one byte. Two use full 8-bit register addresses. One uses an immediate value. In each pair, one form reads the source through a pointer held in a register. The instruction always takes a fixed number of cycles per mode, and `busy` marks that window. A host port loads and inspects the register file while the unit is idle.

Top module: `sub_exec_unit`

## Requirements
- R1: The stored result is destination minus source modulo 256, computed as dst + ~src + 1. It is written to the destination register. The register that holds the source operand, or the pointer to it, keeps its value.
- R2: Opcode 0x22 has one operand byte. Its upper nibble names the destination working register and its lower nibble names the source working register. Working register n is register-file address n. The instruction lasts 4 cycles.
- R3: Opcode 0x23 uses the same packed operand byte as 0x22. The source operand is read at the address held in the named source working register. The instruction lasts 6 cycles.
- R4: Opcodes 0x24 and 0x25 have two operand bytes. The first is the source register address and the second is the destination register address. For 0x25 the source operand is read at the address held in that source register. Both last 6 cycles.
- R5: Opcode 0x26 has two operand bytes. The first is the destination address and the second is the immediate source value. It lasts 6 cycles.
- R6: Flag bit 5 (C) is 1 exactly when the operation borrows, meaning there is no carry out of bit 7. Bit 4 (Z) is 1 exactly when the result is zero.
- R7: Flag bit 3 (S) equals result bit 7. Bit 2 (V) is 1 when the operands differ in sign and the result has the sign of the source.
- R8: Flag bit 1 (D) is 1 after every instruction. Bit 0 (H) is 1 when bit 3 produces no carry in the addition, which signals a nibble borrow.
- R9: If operand bytes arrive back to back, `busy` is high for exactly N-1 cycles after the cycle that accepts the opcode, where N is the mode's cycle count. A late operand byte stretches the window, and the result is still correct.
- R10: An opcode other than 0x22–0x26 produces a one-cycle `illegal` pulse. `busy` stays low, and neither the register file nor the flags change.
- R11: A host write takes effect at the next clock edge when the unit is idle and is ignored while `busy` is high. The host read data shows the addressed register combinationally.
- R12: Synchronous reset clears the flags, every register-file entry and the `illegal` output, and returns the unit to idle with `in_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction byte present |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Unit will take a byte this cycle |
| busy | output | 1 | Instruction in progress |
| illegal | output | 1 | One-cycle pulse for an unknown opcode |
| flags_out | output | 6 | Condition bits {C,Z,S,V,D,H} |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 8 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Register contents at host_addr |

## Verification
The assertions assume that an instruction's operand bytes follow its opcode on the same stream. They also assume the host port does not try to write while an instruction is in flight. Beyond those, they only rely on reset having been applied. The stimulus always sends the full byte count for each opcode and loads the register file only between instructions. It makes a single deliberate host write during a busy window, to show that such a write is dropped. The pointer registers used by the indirect modes are loaded before each vector, so every indirect read lands on a known register.

// File: rtl/sub_pkg.sv
package sub_pkg;

    localparam int DW  = 8;
    localparam int AW  = 8;
    localparam int WN  = 4;
    localparam int CW  = 4;

    localparam logic [7:0] OP_WW  = 8'h22;
    localparam logic [7:0] OP_WIW = 8'h23;
    localparam logic [7:0] OP_RR  = 8'h24;
    localparam logic [7:0] OP_RIR = 8'h25;
    localparam logic [7:0] OP_RIM = 8'h26;

    localparam logic [CW-1:0] CYC_SHORT = 4'd4;
    localparam logic [CW-1:0] CYC_LONG  = 4'd6;

    typedef enum logic [2:0] {
        MD_WW,
        MD_WIW,
        MD_RR,
        MD_RIR,
        MD_RIM
    } mode_e;

    typedef struct packed {
        logic          legal;
        mode_e         mode;
        logic          two_ops;
        logic [CW-1:0] cycles;
    } dec_t;

    typedef struct packed {
        logic c;
        logic z;
        logic s;
        logic v;
        logic d;
        logic h;
    } flags_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BYTES,
        ST_WAIT
    } state_e;

    function automatic logic src_indirect(input mode_e m);
        return (m == MD_WIW) || (m == MD_RIR);
    endfunction

    function automatic logic nibble_format(input mode_e m);
        return (m == MD_WW) || (m == MD_WIW);
    endfunction

endpackage

// File: rtl/sub_decode.sv
module sub_decode
    import sub_pkg::*;
(
    input  logic [7:0] opcode,
    output dec_t       dec
);
    always_comb begin
        dec = '{legal: 1'b0, mode: MD_WW, two_ops: 1'b0, cycles: CYC_SHORT};
        case (opcode)
            OP_WW:  dec = '{legal: 1'b1, mode: MD_WW,  two_ops: 1'b0, cycles: CYC_SHORT};
            OP_WIW: dec = '{legal: 1'b1, mode: MD_WIW, two_ops: 1'b0, cycles: CYC_LONG};
            OP_RR:  dec = '{legal: 1'b1, mode: MD_RR,  two_ops: 1'b1, cycles: CYC_LONG};
            OP_RIR: dec = '{legal: 1'b1, mode: MD_RIR, two_ops: 1'b1, cycles: CYC_LONG};
            OP_RIM: dec = '{legal: 1'b1, mode: MD_RIM, two_ops: 1'b1, cycles: CYC_LONG};
            default: ;
        endcase
    end
endmodule

// File: rtl/sub_alu.sv
module sub_alu
    import sub_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output flags_t       fl
);
    logic [W:0] full;
    logic [4:0] low;

    always_comb begin
        full = {1'b0, a} + {1'b0, ~b} + (W+1)'(1);
        low  = {1'b0, a[3:0]} + {1'b0, ~b[3:0]} + 5'd1;
        res  = full[W-1:0];
        fl.c = ~full[W];
        fl.z = (full[W-1:0] == '0);
        fl.s = full[W-1];
        fl.v = (a[W-1] ^ b[W-1]) & (full[W-1] ~^ b[W-1]);
        fl.d = 1'b1;
        fl.h = ~low[4];
    end
endmodule

// File: rtl/sub_regfile.sv
module sub_regfile #(
    parameter int DW = 8,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] dst_addr,
    input  logic [AW-1:0] src_addr,
    input  logic [AW-1:0] host_addr,
    output logic [DW-1:0] dst_data,
    output logic [DW-1:0] src_data,
    output logic [DW-1:0] ind_data,
    output logic [DW-1:0] host_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    generate
        if (DW >= AW) begin : g_ptr_slice
            assign ptr = src_data[AW-1:0];
        end else begin : g_ptr_ext
            assign ptr = AW'(src_data);
        end
    endgenerate

    assign dst_data  = mem[dst_addr];
    assign src_data  = mem[src_addr];
    assign ind_data  = mem[ptr];
    assign host_data = mem[host_addr];
endmodule

// File: rtl/sub_exec_unit.sv
module sub_exec_unit
    import sub_pkg::*;
#(
    parameter int DATA_W = sub_pkg::DW,
    parameter int ADDR_W = sub_pkg::AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_byte,
    output logic              in_ready,
    output logic              busy,
    output logic              illegal,
    output logic [5:0]        flags_out,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata
);
    localparam logic [CW-1:0] CNT_MAX = '1;

    state_e            state_q;
    dec_t              dec_in, dec_q;
    logic [DATA_W-1:0] b1_q, b2_q;
    logic [CW-1:0]     cyc_q;
    logic              idx_q;
    flags_t            flags_q, alu_fl;
    logic              illegal_q;

    logic              accept_op, fin;
    logic [ADDR_W-1:0] dst_addr, src_addr, rf_waddr;
    logic [DATA_W-1:0] dst_val, src_val, src_data, ind_data, alu_res, rf_wdata;
    logic              rf_we;

    sub_decode u_dec (.opcode(in_byte), .dec(dec_in));

    assign accept_op = (state_q == ST_IDLE) && in_valid;
    assign fin       = (state_q == ST_WAIT) && (cyc_q >= dec_q.cycles - CW'(1));
    assign in_ready  = (state_q == ST_IDLE) || (state_q == ST_BYTES);
    assign busy      = (state_q != ST_IDLE);
    assign illegal   = illegal_q;
    assign flags_out = flags_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            dec_q     <= '0;
            b1_q      <= '0;
            b2_q      <= '0;
            cyc_q     <= '0;
            idx_q     <= 1'b0;
            flags_q   <= '0;
            illegal_q <= 1'b0;
        end else begin
            illegal_q <= accept_op && !dec_in.legal;
            if (busy && cyc_q != CNT_MAX) cyc_q <= cyc_q + CW'(1);
            case (state_q)
                ST_IDLE: begin
                    if (accept_op && dec_in.legal) begin
                        dec_q   <= dec_in;
                        state_q <= ST_BYTES;
                        cyc_q   <= CW'(1);
                        idx_q   <= 1'b0;
                    end
                end
                ST_BYTES: begin
                    if (in_valid) begin
                        if (!idx_q) b1_q <= in_byte;
                        else        b2_q <= in_byte;
                        idx_q <= 1'b1;
                        if (idx_q || !dec_q.two_ops) state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (fin) begin
                        flags_q <= alu_fl;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        dst_addr = '0;
        src_addr = '0;
        if (nibble_format(dec_q.mode)) begin
            dst_addr = ADDR_W'(b1_q[DATA_W-1 -: WN]);
            src_addr = ADDR_W'(b1_q[WN-1:0]);
        end else if (dec_q.mode == MD_RIM) begin
            dst_addr = b1_q[ADDR_W-1:0];
        end else begin
            src_addr = b1_q[ADDR_W-1:0];
            dst_addr = b2_q[ADDR_W-1:0];
        end
    end

    always_comb begin
        if (dec_q.mode == MD_RIM)            src_val = b2_q;
        else if (src_indirect(dec_q.mode))   src_val = ind_data;
        else                                 src_val = src_data;
    end

    assign rf_we    = fin || (host_we && !busy);
    assign rf_waddr = fin ? dst_addr : host_addr;
    assign rf_wdata = fin ? alu_res  : host_wdata;

    sub_regfile #(.DW(DATA_W), .AW(ADDR_W)) u_rf (
        .clk      (clk),
        .rst      (rst),
        .we       (rf_we),
        .waddr    (rf_waddr),
        .wdata    (rf_wdata),
        .dst_addr (dst_addr),
        .src_addr (src_addr),
        .host_addr(host_addr),
        .dst_data (dst_val),
        .src_data (src_data),
        .ind_data (ind_data),
        .host_data(host_rdata)
    );

    sub_alu #(.W(DATA_W)) u_alu (
        .a  (dst_val),
        .b  (src_val),
        .res(alu_res),
        .fl (alu_fl)
    );

    logic signed [DATA_W:0] sdiff;
    assign sdiff = $signed({dst_val[DATA_W-1], dst_val}) - $signed({src_val[DATA_W-1], src_val});

    assert_borrow_R6: assert property (@(posedge clk) disable iff (rst)
        fin |-> (alu_fl.c == (dst_val < src_val)));

    assert_zero_R6: assert property (@(posedge clk) disable iff (rst)
        fin |-> (alu_fl.z == (dst_val == src_val)));

    assert_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        fin |-> (alu_fl.v == (sdiff[DATA_W] != sdiff[DATA_W-1])));

    assert_dflag_R8: assert property (@(posedge clk) disable iff (rst)
        fin |=> flags_out[1]);

    assert_start_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(in_valid));

    assert_illegal_idle_R10: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!busy && $stable(flags_out)));

endmodule

// File: tb/tb_sub_exec_unit.sv
module tb_sub_exec_unit;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = '0;
    logic       in_ready, busy, illegal;
    logic [5:0] flags_out;
    logic       host_we = 1'b0;
    logic [7:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    always #10 clk = ~clk;

    sub_exec_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .busy(busy), .illegal(illegal), .flags_out(flags_out),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata)
    );

    // {r1 preload, opcode, byte1, byte2, expected r1, expected flags, cycles}
    localparam logic [55:0] VEC [10] = '{
        {8'h12, 8'h22, 8'h12, 8'h00, 8'h0F, 8'h03, 8'd4},
        {8'h12, 8'h23, 8'h12, 8'h00, 8'h08, 8'h03, 8'd6},
        {8'h21, 8'h24, 8'h02, 8'h01, 8'h1E, 8'h03, 8'd6},
        {8'h21, 8'h25, 8'h02, 8'h01, 8'h17, 8'h03, 8'd6},
        {8'h21, 8'h26, 8'h01, 8'h90, 8'h91, 8'h2E, 8'd6},
        {8'h21, 8'h26, 8'h01, 8'h65, 8'hBC, 8'h2B, 8'd6},
        {8'h05, 8'h26, 8'h01, 8'h05, 8'h00, 8'h12, 8'd6},
        {8'h80, 8'h26, 8'h01, 8'h01, 8'h7F, 8'h07, 8'd6},
        {8'h7F, 8'h26, 8'h01, 8'hFF, 8'h80, 8'h2E, 8'd6},
        {8'h12, 8'h22, 8'h11, 8'h00, 8'h00, 8'h12, 8'd4}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_read(input logic [7:0] a, output logic [7:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic run_instr(input logic [7:0] op, input logic [7:0] b1, input logic [7:0] b2,
                             input int gap, input bit poke, output int bcount);
        int nb;
        nb = (op == 8'h22 || op == 8'h23) ? 1 : 2;
        @(negedge clk);
        in_valid = 1'b1; in_byte = op;
        @(negedge clk);
        bcount = 0;
        for (int k = 0; k < nb; k++) begin
            if (k == 1 && gap > 0) begin
                in_valid = 1'b0;
                for (int g = 0; g < gap; g++) begin
                    if (busy) bcount++;
                    @(negedge clk);
                end
                in_valid = 1'b1;
            end
            in_byte = (k == 0) ? b1 : b2;
            if (busy) bcount++;
            if (poke) begin
                host_we = 1'b1; host_addr = 8'h05; host_wdata = 8'hAA;
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
        while (busy) begin
            bcount++;
            @(negedge clk);
        end
        host_we = 1'b0;
    endtask

    function automatic string req_of(input logic [7:0] op);
        case (op)
            8'h22: return "R2";
            8'h23: return "R3";
            8'h26: return "R5";
            default: return "R4";
        endcase
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [55:0] v;
        logic [7:0]  rd;
        int          bc;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R12 reset state
        check(flags_out == 6'h00, "R12 flags after reset", flags_out, 0);
        check(!busy && !illegal && in_ready, "R12 idle after reset",
              {busy, illegal, in_ready}, 3'b001);
        host_read(8'h01, rd);
        check(rd == 8'h00, "R12 register cleared", rd, 0);

        for (int i = 0; i < 10; i++) begin
            v = VEC[i];
            host_write(8'h01, v[55:48]);
            host_write(8'h02, 8'h03);
            host_write(8'h03, 8'h0A);
            run_instr(v[47:40], v[39:32], v[31:24], 0, 1'b0, bc);
            host_read(8'h01, rd);
            check(rd == v[23:16], {req_of(v[47:40]), " R1 result"}, rd, v[23:16]);
            check(flags_out == v[13:8], "R6 R7 R8 flags", flags_out, v[13:8]);
            check(bc == int'(v[7:0]) - 1, {"R9 busy length ", req_of(v[47:40])}, bc, int'(v[7:0]) - 1);
            host_read(8'h02, rd);
            check(rd == 8'h03, "R1 source register kept", rd, 8'h03);
            host_read(8'h03, rd);
            check(rd == 8'h0A, "R1 pointed register kept", rd, 8'h0A);
        end

        // R9 late operand byte
        host_write(8'h01, 8'h21);
        run_instr(8'h26, 8'h01, 8'h90, 3, 1'b0, bc);
        host_read(8'h01, rd);
        check(rd == 8'h91, "R9 stalled result", rd, 8'h91);
        check(bc == 6, "R9 stalled busy length", bc, 6);

        // R11 host write during busy dropped, idle write taken
        host_write(8'h05, 8'h33);
        host_read(8'h05, rd);
        check(rd == 8'h33, "R11 idle host write", rd, 8'h33);
        host_write(8'h01, 8'h21);
        run_instr(8'h26, 8'h01, 8'h65, 0, 1'b1, bc);
        host_read(8'h05, rd);
        check(rd == 8'h33, "R11 busy host write ignored", rd, 8'h33);
        host_read(8'h01, rd);
        check(rd == 8'hBC, "R11 instruction unaffected", rd, 8'hBC);

        // R10 illegal opcodes
        foreach (VEC[j]) begin end
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            in_valid = 1'b1; in_byte = (k == 0) ? 8'h27 : 8'h00;
            @(negedge clk);
            in_valid = 1'b0;
            check(illegal && !busy, "R10 illegal pulse, no busy", {illegal, busy}, 2'b10);
            @(negedge clk);
            check(!illegal && !busy, "R10 pulse one cycle", {illegal, busy}, 2'b00);
            check(flags_out == 6'h2B, "R10 flags unchanged", flags_out, 6'h2B);
            host_read(8'h01, rd);
            check(rd == 8'hBC, "R10 registers unchanged", rd, 8'hBC);
        end

        // R12 reset after activity
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        check(flags_out == 6'h00, "R12 flags cleared by reset", flags_out, 0);
        host_read(8'h01, rd);
        check(rd == 8'h00, "R12 register cleared by reset", rd, 0);

        ended = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule